// File: doc/BRIEF.md
# Three-phase PWM output controller

This block converts the outputs of three external carrier timers into six active-low drive signals, a positive and a negative line for each of the U, V and W phases. For every phase the positive line follows the timer when it is high and the negative line follows it when it is low. A per-phase dead-time counter keeps a line from switching on straight after its partner has switched off. A six-bit mask decides which lines may be driven at all. Software writes the mask into a buffer register, and a transfer trigger copies it into the working (shift) register. The trigger is either an external pulse or a self-clearing bit in the control register.

Two modulation modes change the transfer and dead-time rules. In triangular mode the buffer is copied once per software write, and dead time starts only when a timer output falls. In sawtooth mode every trigger copies the buffer and also restarts dead time on all phases. A guard watches the pad-level feedback for a pair whose lines are both low. When it sees one, it latches a flag and can optionally clear the output enable. The block also qualifies a timer interrupt with the reload control signal. Control register writes only take effect while an external protect bit is high.

Top module: `tri_phase_pwm_ctrl`

## Requirements
- R1: The control register resets to 0x00. A write while `prot_en` is 0 leaves it unchanged. Layout: bit 0 interrupt polarity, bit 1 interrupt qualify enable, bit 2 three-phase mode, bit 3 output enable, bit 4 guard enable, bit 5 detect flag, bit 6 sawtooth mode, bit 7 software trigger.
- R2: Bit 7 always reads 0. Writing 1 to it raises one transfer trigger. Writing 1 to bit 5 never sets the flag.
- R3: With bit 2 at 0, all six `drive_n` lines stay high and `irq_out` equals `irq_in`.
- R4: In three-phase mode with bit 3 set and dead time idle, phase k's positive line `drive_n[2k]` is low when its mask bit 2k is 1 and `tmr_in[k]` is 1. Its negative line `drive_n[2k+1]` is low when mask bit 2k+1 is 1 and `tmr_in[k]` is 0.
- R5: If `tmr_in[k]` is first sampled low at clock edge E, both lines of that phase stay high through edge E+D-1, where D is the dead-time register value. The negative line goes low after edge E+D. A rise of the timer output starts no dead time.
- R6: In triangular mode (bit 6 = 0), a buffer write changes nothing until the next trigger, which copies the buffer into the mask once.
- R7: In sawtooth mode (bit 6 = 1), every trigger copies the buffer and holds all six lines high for D clock edges.
- R8: With bit 3 at 0, all six lines stay high.
- R9: In three-phase mode, `pad_fb` bits 2k and 2k+1 both being 0 sets bit 5. The flag stays set until a write puts 0 in bit 5. In normal mode no detection occurs.
- R10: With bit 4 set, a detection clears bit 3 at the same edge that sets bit 5.
- R11: In three-phase mode with bit 1 set, `irq_out` is `irq_in` gated by `reload_sig` = 1 when bit 0 is 0, or by `reload_sig` = 0 when bit 0 is 1. With bit 1 at 0, `irq_out` equals `irq_in`.
- R12: The two lines of a pair are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_en | input | 1 | Write permission for the control register |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| dt_we | input | 1 | Dead-time register write strobe |
| dt_wdata | input | DT_W | Dead-time value in clocks |
| buf_we | input | 1 | Buffer register write strobe |
| buf_wdata | input | 2*NPH | Drive mask to buffer |
| tmr_in | input | NPH | Carrier timer output per phase |
| xfer_trig | input | 1 | External transfer trigger pulse |
| reload_sig | input | 1 | Reload control signal for interrupt qualification |
| irq_in | input | 1 | Timer interrupt request |
| pad_fb | input | 2*NPH | Pad-level feedback of the six drive lines |
| drive_n | output | 2*NPH | Active-low drive lines, positive at 2k, negative at 2k+1 |
| irq_out | output | 1 | Qualified interrupt request |

## Verification
The hardest conditions to reach are the ones the controller itself prevents. Its own drive lines never produce a low-low pair, so the bench drives `pad_fb` directly with single-cycle low pairs, with the guard both off and on and in both modes. The dead-time window is checked edge by edge. In triangular mode the bench lets a timer output fall after a long high. In sawtooth mode it pulses the trigger while all timers are high, so the restart is the only thing that can hold the lines off.

// File: rtl/tpc_pkg.sv
`timescale 1ns/1ps
package tpc_pkg;
  localparam int CTL_W    = 8;
  localparam int TRIG_BIT = 7;
  localparam int DET_BIT  = 5;

  // Packed so that the fields land on control bits 6..0.
  typedef struct packed {
    logic saw;
    logic det;
    logic guard;
    logic out_en;
    logic mode3;
    logic irq_spec;
    logic irq_pol;
  } ctl_t;
endpackage

// File: rtl/tpc_ctrl_reg.sv
`timescale 1ns/1ps
module tpc_ctrl_reg
  import tpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot_en,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             det_hit,
  output ctl_t             ctl,
  output logic             sw_trig,
  output logic [CTL_W-1:0] rd_data
);
  ctl_t ctl_q;
  ctl_t ctl_d;
  logic wr_ok;

  assign wr_ok = wr_en & prot_en;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ok) begin
      ctl_d     = ctl_t'(wr_data[CTL_W-2:0]);
      // the flag can only be cleared by software
      ctl_d.det = ctl_q.det & wr_data[DET_BIT];
    end
    if (det_hit) begin
      ctl_d.det = 1'b1;
      if (ctl_q.guard) begin
        ctl_d.out_en = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  assign ctl     = ctl_q;
  assign sw_trig = wr_ok & wr_data[TRIG_BIT];
  assign rd_data = {1'b0, ctl_q};
endmodule

// File: rtl/tpc_xfer.sv
`timescale 1ns/1ps
module tpc_xfer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         saw,
  input  logic         trig,
  input  logic         buf_we,
  input  logic [W-1:0] buf_wdata,
  output logic [W-1:0] mask
);
  logic [W-1:0] buf_q, buf_d;
  logic [W-1:0] sh_q, sh_d;
  logic         pend_q, pend_d;

  always_comb begin
    buf_d  = buf_q;
    sh_d   = sh_q;
    pend_d = pend_q;
    if (trig && (saw || pend_q)) begin
      sh_d   = buf_q;
      pend_d = 1'b0;
    end
    if (buf_we) begin
      buf_d  = buf_wdata;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      sh_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      sh_q   <= sh_d;
      pend_q <= pend_d;
    end
  end

  assign mask = sh_q;
endmodule

// File: rtl/tpc_phase.sv
`timescale 1ns/1ps
module tpc_phase #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tmr_in,
  input  logic            restart,
  input  logic            run,
  input  logic            en_pos,
  input  logic            en_neg,
  input  logic [DT_W-1:0] dt_val,
  output logic            pos_n,
  output logic            neg_n
);
  logic            tmr_q;
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            fall;
  logic            idle;

  assign fall = tmr_q & ~tmr_in;
  assign idle = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (fall || restart) begin
      cnt_d = dt_val;
    end else if (!idle) begin
      cnt_d = cnt_q - DT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      tmr_q <= tmr_in;
      cnt_q <= cnt_d;
    end
  end

  assign pos_n = ~(run & en_pos &  tmr_q & idle);
  assign neg_n = ~(run & en_neg & ~tmr_q & idle);
endmodule

// File: rtl/tpc_guard.sv
`timescale 1ns/1ps
module tpc_guard #(
  parameter int NPH = 3
) (
  input  logic [2*NPH-1:0] pad_fb,
  input  logic             mode3,
  input  logic             irq_in,
  input  logic             reload_sig,
  input  logic             irq_spec,
  input  logic             irq_pol,
  output logic             det_hit,
  output logic             irq_out
);
  logic [NPH-1:0] pair_low;

  for (genvar k = 0; k < NPH; k++) begin : g_pair
    assign pair_low[k] = ~pad_fb[2*k] & ~pad_fb[2*k+1];
  end

  assign det_hit = mode3 & (|pair_low);
  assign irq_out = (mode3 & irq_spec) ? (irq_in & (reload_sig ^ irq_pol)) : irq_in;
endmodule

// File: rtl/tri_phase_pwm_ctrl.sv
`timescale 1ns/1ps
module tri_phase_pwm_ctrl
  import tpc_pkg::*;
#(
  parameter int NPH  = 3,
  parameter int DT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot_en,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             dt_we,
  input  logic [DT_W-1:0]  dt_wdata,
  input  logic             buf_we,
  input  logic [2*NPH-1:0] buf_wdata,
  input  logic [NPH-1:0]   tmr_in,
  input  logic             xfer_trig,
  input  logic             reload_sig,
  input  logic             irq_in,
  input  logic [2*NPH-1:0] pad_fb,
  output logic [2*NPH-1:0] drive_n,
  output logic             irq_out
);
  localparam int NLINE = 2 * NPH;

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  // dead-time value
  logic [DT_W-1:0] dt_q, dt_d;

  always_comb begin
    dt_d = dt_q;
    if (dt_we) begin
      dt_d = dt_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dt_q <= '0;
    end else begin
      dt_q <= dt_d;
    end
  end

  ctl_t             ctl;
  logic             sw_trig;
  logic             det_hit;
  logic             trig;
  logic [NLINE-1:0] mask;
  logic             run;
  logic             restart;

  tpc_ctrl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .prot_en (prot_en),
    .wr_en   (ctl_we),
    .wr_data (ctl_wdata),
    .det_hit (det_hit),
    .ctl     (ctl),
    .sw_trig (sw_trig),
    .rd_data (ctl_rdata)
  );

  assign trig    = xfer_trig | sw_trig;
  assign run     = ctl.mode3 & ctl.out_en;
  assign restart = ctl.saw & trig;

  tpc_xfer #(.W(NLINE)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .saw       (ctl.saw),
    .trig      (trig),
    .buf_we    (buf_we),
    .buf_wdata (buf_wdata),
    .mask      (mask)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    tpc_phase #(.DT_W(DT_W)) u_ph (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .tmr_in  (tmr_in[k]),
      .restart (restart),
      .run     (run),
      .en_pos  (mask[2*k]),
      .en_neg  (mask[2*k+1]),
      .dt_val  (dt_q),
      .pos_n   (drive_n[2*k]),
      .neg_n   (drive_n[2*k+1])
    );
  end

  tpc_guard #(.NPH(NPH)) u_guard (
    .pad_fb     (pad_fb),
    .mode3      (ctl.mode3),
    .irq_in     (irq_in),
    .reload_sig (reload_sig),
    .irq_spec   (ctl.irq_spec),
    .irq_pol    (ctl.irq_pol),
    .det_hit    (det_hit),
    .irq_out    (irq_out)
  );
endmodule

// File: rtl/tpc_checker.sv
`timescale 1ns/1ps
module tpc_checker #(
  parameter int NPH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prot_en,
  input logic [7:0]       ctl_rdata,
  input logic [2*NPH-1:0] pad_fb,
  input logic [2*NPH-1:0] drive_n,
  input logic             irq_in,
  input logic             irq_out
);
  logic det_any;

  always_comb begin
    det_any = 1'b0;
    for (int k = 0; k < NPH; k++) begin
      if (!pad_fb[2*k] && !pad_fb[2*k+1]) det_any = 1'b1;
    end
  end

  for (genvar k = 0; k < NPH; k++) begin : g_pair
    assert_pair_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_n[2*k] || drive_n[2*k+1]));
  end

  assert_write_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_en && !det_any) |=> $stable(ctl_rdata));

  assert_normal_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[2] |-> ((&drive_n) && (irq_out == irq_in)));

  assert_outen_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[3] |-> (&drive_n));

  assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rdata[5]) |-> $past(det_any && ctl_rdata[2]));

  assert_guard_kill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (det_any && ctl_rdata[2] && ctl_rdata[4]) |=> !ctl_rdata[3]);
endmodule

bind tri_phase_pwm_ctrl tpc_checker #(.NPH(NPH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prot_en   (prot_en),
  .ctl_rdata (ctl_rdata),
  .pad_fb    (pad_fb),
  .drive_n   (drive_n),
  .irq_in    (irq_in),
  .irq_out   (irq_out)
);

// File: tb/sim_tri_phase_pwm_ctrl.sv
`timescale 1ns/1ps
module sim_tri_phase_pwm_ctrl;
  logic       clk;
  logic       rst_n;
  logic       prot_en;
  logic       ctl_we;
  logic [7:0] ctl_wdata;
  logic [7:0] ctl_rdata;
  logic       dt_we;
  logic [7:0] dt_wdata;
  logic       buf_we;
  logic [5:0] buf_wdata;
  logic [2:0] tmr_in;
  logic       xfer_trig;
  logic       reload_sig;
  logic       irq_in;
  logic [5:0] pad_fb;
  logic [5:0] drive_n;
  logic       irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  tri_phase_pwm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .dt_we(dt_we), .dt_wdata(dt_wdata),
    .buf_we(buf_we), .buf_wdata(buf_wdata),
    .tmr_in(tmr_in), .xfer_trig(xfer_trig), .reload_sig(reload_sig),
    .irq_in(irq_in), .pad_fb(pad_fb), .drive_n(drive_n), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected drive with idle dead time: positive on timer high, negative on low
  function automatic logic [5:0] exp_drive(input logic [2:0] t, input logic [5:0] m);
    logic [5:0] r;
    for (int k = 0; k < 3; k++) begin
      r[2*k]   = ~(m[2*k]   &  t[k]);
      r[2*k+1] = ~(m[2*k+1] & ~t[k]);
    end
    return r;
  endfunction

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_buf(input logic [5:0] d);
    @(negedge clk); buf_we = 1'b1; buf_wdata = d;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic wr_dt(input logic [7:0] d);
    @(negedge clk); dt_we = 1'b1; dt_wdata = d;
    @(negedge clk); dt_we = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); xfer_trig = 1'b1;
    @(negedge clk); xfer_trig = 1'b0;
  endtask

  task automatic set_tmr(input logic [2:0] t);
    @(negedge clk); tmr_in = t;
    @(negedge clk);
  endtask

  task automatic t_reset();
    irq_in = 1'b1; #1;
    chk("R1", "reset ctl", ctl_rdata, 8'h00);
    chk("R3", "reset drive", {2'b0, drive_n}, 8'h3F);
    chk("R3", "reset irq pass", {7'b0, irq_out}, 8'h01);
    irq_in = 1'b0;
  endtask

  task automatic t_protect();
    prot_en = 1'b0;
    wr_ctl(8'h0C);
    chk("R1", "locked write", ctl_rdata, 8'h00);
    prot_en = 1'b1;
    wr_ctl(8'hFF);
    chk("R2", "trig and flag read", ctl_rdata, 8'h5F);
    wr_ctl(8'h00);
    chk("R1", "open write", ctl_rdata, 8'h00);
  endtask

  task automatic t_normal();
    wr_buf(6'h3F);
    wr_ctl(8'h8B);
    set_tmr(3'b101);
    irq_in = 1'b1; reload_sig = 1'b1; #1;
    chk("R3", "normal ctl", ctl_rdata, 8'h0B);
    chk("R3", "normal drive", {2'b0, drive_n}, 8'h3F);
    chk("R3", "normal irq", {7'b0, irq_out}, 8'h01);
    irq_in = 1'b0;
  endtask

  task automatic t_outputs();
    wr_ctl(8'h0C);
    chk("R4", "drive 101", {2'b0, drive_n}, {2'b0, exp_drive(3'b101, 6'h3F)});
    set_tmr(3'b010);
    chk("R4", "drive 010", {2'b0, drive_n}, {2'b0, exp_drive(3'b010, 6'h3F)});
    wr_buf(6'h15);
    wr_ctl(8'h8C);
    chk("R4", "masked drive", {2'b0, drive_n}, {2'b0, exp_drive(3'b010, 6'h15)});
  endtask

  task automatic t_tri();
    set_tmr(3'b111);
    wr_buf(6'h2A);
    chk("R6", "no copy before trigger", {2'b0, drive_n}, {2'b0, exp_drive(3'b111, 6'h15)});
    pulse_trig();
    chk("R6", "copy on trigger", {2'b0, drive_n}, {2'b0, exp_drive(3'b111, 6'h2A)});
    wr_buf(6'h3F);
    repeat (3) @(negedge clk);
    chk("R6", "held until trigger", {2'b0, drive_n}, {2'b0, exp_drive(3'b111, 6'h2A)});
    pulse_trig();
    chk("R6", "second copy", {2'b0, drive_n}, {2'b0, exp_drive(3'b111, 6'h3F)});
  endtask

  task automatic t_dead();
    wr_dt(8'd3);
    @(negedge clk); tmr_in = 3'b110;
    for (int k = 0; k <= 3; k++) begin
      @(negedge clk);
      chk("R5", "U pair in dead time", {6'b0, drive_n[1:0]}, (k >= 3) ? 8'h01 : 8'h03);
      chk("R12", "other pairs", {4'b0, drive_n[5:2]}, 8'h0A);
    end
    set_tmr(3'b111);
    chk("R5", "rise not delayed", {2'b0, drive_n}, 8'h2A);
  endtask

  task automatic t_saw();
    wr_ctl(8'h4C);
    chk("R7", "saw steady", {2'b0, drive_n}, 8'h2A);
    wr_buf(6'h15);
    @(negedge clk); xfer_trig = 1'b1;
    for (int k = 0; k <= 3; k++) begin
      @(negedge clk);
      if (k == 0) xfer_trig = 1'b0;
      chk("R7", "restart hold", {2'b0, drive_n}, (k >= 3) ? 8'h2A : 8'h3F);
    end
    wr_buf(6'h2A);
    pulse_trig();
    repeat (3) @(negedge clk);
    chk("R7", "copy each trigger", {2'b0, drive_n}, {2'b0, exp_drive(3'b111, 6'h2A)});
    wr_buf(6'h3F);
    pulse_trig();
    repeat (3) @(negedge clk);
    chk("R7", "copy again", {2'b0, drive_n}, 8'h2A);
    wr_dt(8'd0);
  endtask

  task automatic t_outen();
    wr_ctl(8'h04);
    chk("R8", "outputs disabled", {2'b0, drive_n}, 8'h3F);
    chk("R8", "ctl readback", ctl_rdata, 8'h04);
  endtask

  task automatic t_detect();
    wr_ctl(8'h0C);
    @(negedge clk); pad_fb = 6'h3C;
    @(negedge clk); pad_fb = 6'h3F;
    chk("R9", "flag set, enable kept", ctl_rdata, 8'h2C);
    repeat (2) @(negedge clk);
    chk("R9", "flag sticky", ctl_rdata, 8'h2C);
    wr_ctl(8'h2C);
    chk("R9", "write 1 keeps flag", ctl_rdata, 8'h2C);
    wr_ctl(8'h0C);
    chk("R9", "write 0 clears", ctl_rdata, 8'h0C);
    wr_ctl(8'h1C);
    @(negedge clk); pad_fb = 6'h0F;
    @(negedge clk); pad_fb = 6'h3F;
    chk("R10", "guard clears enable", ctl_rdata, 8'h34);
    chk("R10", "guard drive", {2'b0, drive_n}, 8'h3F);
    wr_ctl(8'h00);
    @(negedge clk); pad_fb = 6'h30;
    @(negedge clk); pad_fb = 6'h3F;
    chk("R9", "no detect in normal mode", ctl_rdata, 8'h00);
  endtask

  task automatic t_irq();
    wr_ctl(8'h06);
    irq_in = 1'b1; reload_sig = 1'b1; #1;
    chk("R11", "pol0 reload1", {7'b0, irq_out}, 8'h01);
    reload_sig = 1'b0; #1;
    chk("R11", "pol0 reload0", {7'b0, irq_out}, 8'h00);
    wr_ctl(8'h07);
    #1;
    chk("R11", "pol1 reload0", {7'b0, irq_out}, 8'h01);
    reload_sig = 1'b1; #1;
    chk("R11", "pol1 reload1", {7'b0, irq_out}, 8'h00);
    wr_ctl(8'h05);
    #1;
    chk("R11", "unqualified", {7'b0, irq_out}, 8'h01);
    irq_in = 1'b0; #1;
    chk("R11", "unqualified low", {7'b0, irq_out}, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-none: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; prot_en = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
    dt_we = 1'b0; dt_wdata = '0; buf_we = 1'b0; buf_wdata = '0;
    tmr_in = '0; xfer_trig = 1'b0; reload_sig = 1'b0; irq_in = 1'b0;
    pad_fb = 6'h3F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_protect();
    t_normal();
    t_outputs();
    t_tri();
    t_dead();
    t_saw();
    t_outen();
    t_detect();
    t_irq();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule